// File: doc/BRIEF.md
# Supervisor Data Access Guard

This block sits after address translation and rules on each data access: the access either goes ahead or raises a page fault. It applies two rules. Under the prevention rule, a supervisor access may not touch a page that user code can reach. Under the write-protect rule, a supervisor write needs every paging level to grant write permission. An override flag lifts the prevention rule for ordinary privileged code. The override is not honoured when a privilege-3 access is flagged as an implicit system access, such as a descriptor-table, interrupt-table or task-state access.

The block keeps two pieces of state. One is the prevention-enable bit, which lives at bit 21 of a control-register write port. The other is the override flag, which is changed by separate set and clear commands. A capability strap gates both. The enable bit can only become 1 when capability bit 20 is 1. The set and clear commands only take effect when that capability bit is 1; otherwise they raise an illegal-operation pulse.

Requests use a valid/ready stream and results are returned on a second valid/ready stream, one cycle later. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 when the result slot is empty or the downstream side takes the result in that cycle. A result that is waiting holds its values unchanged until `res_ready` is 1.

Top module: `sda_guard`

## Requirements
- R1: After reset the prevention-enable bit is 0. A control write loads bit 21 of the write data into the enable bit only when bit 20 of the capability vector is 1; otherwise the write leaves the bit at 0. No other data bit affects the enable bit.
- R2: When `req_pg_en` is 0, the access never faults, whatever the translation-valid flag, the enable bit and the page bits hold.
- R3: When paging is on and `req_xlat_ok` is 0, the access faults.
- R4: Privilege levels 0, 1 and 2 (`req_priv` = 0..2) make supervisor accesses. At privilege 3, only accesses with `req_implicit`=1 are supervisor accesses. A privilege-3 access that is not implicit, has a valid translation and has paging on never faults.
- R5: With the enable bit 1 and the override flag 0, a supervisor read faults on a user page (`req_us` bit is 1 at every used level). It is allowed when at least one used level has its `req_us` bit at 0.
- R6: With privilege below 3 and the override flag 1, a supervisor read is allowed to any validly translated page.
- R7: An implicit privilege-3 access is subject to the prevention rule whatever the override flag holds.
- R8: With `req_wp`=0: when the enable bit is 0, a supervisor write never faults on a valid translation; when the enable bit is 1, a supervisor write follows the same rule as a read.
- R9: With `req_wp`=1, a supervisor write also faults unless the `req_rw` bit is 1 at every used level. This fault combines with the prevention result; either one is enough to fault.
- R10: Level i (bit i of `req_us`/`req_rw`) is used when i < `req_lvl_cnt`. A count below 2 counts as 2 and a count above 4 counts as 4. Bits of unused levels have no effect.
- R11: The set command makes the override flag 1 and the clear command makes it 0; the clear wins when both are given. When capability bit 20 is 0, both commands are ignored and `illegal_op` is 1 for the one cycle after the command.
- R12: `res_valid` rises one cycle after a request is taken, with `res_fault` and `res_write` (the echo of `req_write`). A result that is not taken holds all its values. `req_ready` = !`res_valid` || `res_ready`. `res_fault` is 0 whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_vec | input | 32 | Capability strap vector; bit 20 enables the feature |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control register write data; bit 21 is the prevention enable |
| ovr_set | input | 1 | Set the override flag |
| ovr_clr | input | 1 | Clear the override flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 2 | Privilege level 0..3 |
| req_implicit | input | 1 | Implicit system-structure access |
| req_pg_en | input | 1 | Paging enabled |
| req_wp | input | 1 | Write-protect control |
| req_xlat_ok | input | 1 | Translation is valid |
| req_lvl_cnt | input | 3 | Number of active paging levels |
| req_us | input | 4 | User/supervisor bit per level |
| req_rw | input | 4 | Read/write bit per level |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream takes the result |
| res_fault | output | 1 | Access must raise a page fault |
| res_write | output | 1 | Faulting/allowed access was a write |
| prev_en | output | 1 | Current prevention-enable bit |
| ovr_flag | output | 1 | Current override flag |
| illegal_op | output | 1 | One-cycle pulse after a command refused for lack of capability |

## Verification
The bench builds the block with its defaults: four paging levels, the enable bit at position 21, the capability bit at position 20 and 32-bit control and capability words. With four levels, counts of 2, 3 and 4 can all be tried on the same page-bit pattern, so a supervisor-only marking held in an unused level can be seen to have no effect. The out-of-range counts 0 and 7 can also be shown to clamp. Back-pressure on the result stream checks that a pending fault is held and that intake stops while it waits.

// File: rtl/sda_guard_pkg.sv
package sda_guard_pkg;

  typedef logic [1:0] priv_t;

  localparam priv_t PRIV_APP = 2'd3;

  typedef struct packed {
    logic fault;
    logic write;
  } verdict_t;

  typedef struct packed {
    logic  write;
    priv_t priv;
    logic  implicit_acc;
    logic  pg_en;
    logic  wp;
    logic  xlat_ok;
  } req_attr_t;

endpackage

// File: rtl/sda_ctl_state.sv
module sda_ctl_state #(
  parameter int CTL_W   = 32,
  parameter int CAP_W   = 32,
  parameter int EN_BIT  = 21,
  parameter int CAP_BIT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] cap_vec,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             ovr_set,
  input  logic             ovr_clr,
  output logic             prev_en_q,
  output logic             ovr_q,
  output logic             illegal_q
);

  logic cap_ok;
  logic cmd_any;
  logic unused_bits;

  assign cap_ok      = cap_vec[CAP_BIT];
  assign cmd_any     = ovr_set | ovr_clr;
  assign unused_bits = ^{ctl_wr_data, cap_vec};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_en_q <= 1'b0;
    end else if (ctl_wr_en) begin
      prev_en_q <= ctl_wr_data[EN_BIT] & cap_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (cap_ok) begin
      if (ovr_clr) begin
        ovr_q <= 1'b0;
      end else if (ovr_set) begin
        ovr_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= cmd_any & ~cap_ok;
    end
  end

  AST_EN_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prev_en_q) |-> $past(cap_ok)); // R1

  AST_OVR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ok |=> $stable(ovr_q)); // R11

  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_any && !cap_ok) |=> illegal_q); // R11

endmodule

// File: rtl/sda_lvl_reduce.sv
module sda_lvl_reduce #(
  parameter int MAX_LVL = 4,
  parameter int MIN_LVL = 2,
  parameter int LVL_CW  = $clog2(MAX_LVL + 1)
) (
  input  logic [LVL_CW-1:0]  lvl_cnt,
  input  logic [MAX_LVL-1:0] us_bits,
  input  logic [MAX_LVL-1:0] rw_bits,
  output logic               sup_only,
  output logic               all_wr
);

  localparam logic [LVL_CW-1:0] MIN_C = LVL_CW'(MIN_LVL);
  localparam logic [LVL_CW-1:0] MAX_C = LVL_CW'(MAX_LVL);

  logic [LVL_CW-1:0]  eff_cnt;
  logic [MAX_LVL-1:0] used;
  logic [MAX_LVL-1:0] sup_hit;
  logic [MAX_LVL-1:0] ro_hit;

  always_comb begin
    if (lvl_cnt < MIN_C) begin
      eff_cnt = MIN_C;
    end else if (lvl_cnt > MAX_C) begin
      eff_cnt = MAX_C;
    end else begin
      eff_cnt = lvl_cnt;
    end
  end

  for (genvar g = 0; g < MAX_LVL; g++) begin : g_lvl
    assign used[g]    = eff_cnt > LVL_CW'(g);
    assign sup_hit[g] = used[g] & ~us_bits[g];
    assign ro_hit[g]  = used[g] & ~rw_bits[g];
  end

  assign sup_only = |sup_hit;
  assign all_wr   = ~|ro_hit;

endmodule

// File: rtl/sda_judge.sv
module sda_judge
  import sda_guard_pkg::*;
(
  input  req_attr_t attr,
  input  logic      prev_en,
  input  logic      ovr,
  input  logic      sup_only,
  input  logic      all_wr,
  output logic      fault
);

  logic is_sup;
  logic rule_live;
  logic prev_hit;
  logic wp_hit;

  always_comb begin
    is_sup    = (attr.priv != PRIV_APP) | attr.implicit_acc;
    rule_live = prev_en & ((attr.priv == PRIV_APP) | ~ovr);
    prev_hit  = is_sup & rule_live & ~sup_only;
    wp_hit    = is_sup & attr.write & attr.wp & ~all_wr;
    if (!attr.pg_en) begin
      fault = 1'b0;
    end else if (!attr.xlat_ok) begin
      fault = 1'b1;
    end else begin
      fault = prev_hit | wp_hit;
    end
  end

endmodule

// File: rtl/sda_guard.sv
module sda_guard
  import sda_guard_pkg::*;
#(
  parameter int MAX_LVL = 4,
  parameter int MIN_LVL = 2,
  parameter int CTL_W   = 32,
  parameter int CAP_W   = 32,
  parameter int EN_BIT  = 21,
  parameter int CAP_BIT = 20,
  parameter int LVL_CW  = $clog2(MAX_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAP_W-1:0]   cap_vec,
  input  logic               ctl_wr_en,
  input  logic [CTL_W-1:0]   ctl_wr_data,
  input  logic               ovr_set,
  input  logic               ovr_clr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_priv,
  input  logic               req_implicit,
  input  logic               req_pg_en,
  input  logic               req_wp,
  input  logic               req_xlat_ok,
  input  logic [LVL_CW-1:0]  req_lvl_cnt,
  input  logic [MAX_LVL-1:0] req_us,
  input  logic [MAX_LVL-1:0] req_rw,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_fault,
  output logic               res_write,
  output logic               prev_en,
  output logic               ovr_flag,
  output logic               illegal_op
);

  req_attr_t attr;
  verdict_t  out_q;
  logic      sup_only;
  logic      all_wr;
  logic      fault_c;
  logic      fire;

  assign attr = '{write:        req_write,
                  priv:         req_priv,
                  implicit_acc: req_implicit,
                  pg_en:        req_pg_en,
                  wp:           req_wp,
                  xlat_ok:      req_xlat_ok};

  sda_ctl_state #(
    .CTL_W  (CTL_W),
    .CAP_W  (CAP_W),
    .EN_BIT (EN_BIT),
    .CAP_BIT(CAP_BIT)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_vec    (cap_vec),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wr_data(ctl_wr_data),
    .ovr_set    (ovr_set),
    .ovr_clr    (ovr_clr),
    .prev_en_q  (prev_en),
    .ovr_q      (ovr_flag),
    .illegal_q  (illegal_op)
  );

  sda_lvl_reduce #(
    .MAX_LVL(MAX_LVL),
    .MIN_LVL(MIN_LVL),
    .LVL_CW (LVL_CW)
  ) u_lvl (
    .lvl_cnt (req_lvl_cnt),
    .us_bits (req_us),
    .rw_bits (req_rw),
    .sup_only(sup_only),
    .all_wr  (all_wr)
  );

  sda_judge u_judge (
    .attr    (attr),
    .prev_en (prev_en),
    .ovr     (ovr_flag),
    .sup_only(sup_only),
    .all_wr  (all_wr),
    .fault   (fault_c)
  );

  assign req_ready = ~res_valid | res_ready;
  assign fire      = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      out_q     <= '0;
    end else if (fire) begin
      res_valid   <= 1'b1;
      out_q.fault <= fault_c;
      out_q.write <= req_write;
    end else if (res_ready) begin
      res_valid   <= 1'b0;
      out_q.fault <= 1'b0;
    end
  end

  assign res_fault = out_q.fault;
  assign res_write = out_q.write;

  AST_NOPAGE_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_pg_en) |=> (res_valid && !res_fault)); // R2

  AST_BAD_XLAT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_pg_en && !req_xlat_ok) |=> (res_valid && res_fault)); // R3

  AST_APP_PLAIN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_pg_en && req_xlat_ok && req_priv == PRIV_APP && !req_implicit)
      |=> !res_fault); // R4

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fault) && $stable(res_write))); // R12

  AST_NO_STRAY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_fault); // R12

endmodule

// File: tb/sda_guard_bench.sv
module sda_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cap_vec = '0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        ovr_set = 1'b0;
  logic        ovr_clr = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_priv = '0;
  logic        req_implicit = 1'b0;
  logic        req_pg_en = 1'b1;
  logic        req_wp = 1'b0;
  logic        req_xlat_ok = 1'b1;
  logic [2:0]  req_lvl_cnt = 3'd4;
  logic [3:0]  req_us = '0;
  logic [3:0]  req_rw = '1;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_fault;
  logic        res_write;
  logic        prev_en;
  logic        ovr_flag;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sda_guard u_sda_guard (
    .clk(clk), .rst_n(rst_n), .cap_vec(cap_vec), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_data(ctl_wr_data), .ovr_set(ovr_set), .ovr_clr(ovr_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_priv(req_priv), .req_implicit(req_implicit), .req_pg_en(req_pg_en),
    .req_wp(req_wp), .req_xlat_ok(req_xlat_ok), .req_lvl_cnt(req_lvl_cnt),
    .req_us(req_us), .req_rw(req_rw), .res_valid(res_valid),
    .res_ready(res_ready), .res_fault(res_fault), .res_write(res_write),
    .prev_en(prev_en), .ovr_flag(ovr_flag), .illegal_op(illegal_op)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] pr, input logic imp,
                        input logic pg, input logic wp, input logic ok,
                        input logic [2:0] lvl, input logic [3:0] us, input logic [3:0] rw,
                        input logic exp_fault, input string req, input string what);
    req_write = wr; req_priv = pr; req_implicit = imp; req_pg_en = pg;
    req_wp = wp; req_xlat_ok = ok; req_lvl_cnt = lvl; req_us = us; req_rw = rw;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({31'd0, res_valid}, 32'd1, "R12", {what, " valid"});
    chk({31'd0, res_fault}, {31'd0, exp_fault}, req, what);
  endtask

  task automatic ctl_write(input logic [31:0] d);
    ctl_wr_data = d; ctl_wr_en = 1'b1;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic cmd(input logic s, input logic c);
    ovr_set = s; ovr_clr = c;
    @(negedge clk);
    ovr_set = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk({31'd0, prev_en}, 0, "R1", "enable after reset");
    chk({31'd0, ovr_flag}, 0, "R11", "override after reset");
    chk({31'd0, res_valid}, 0, "R12", "no result after reset");
    chk({31'd0, req_ready}, 1, "R12", "ready after reset");
  endtask

  task automatic t_enable_gate();
    cap_vec = '0;
    ctl_write(32'h0020_0000);
    chk({31'd0, prev_en}, 0, "R1", "enable without capability");
    cap_vec = 32'h0010_0000;
    ctl_write(32'hFFDF_FFFF);
    chk({31'd0, prev_en}, 0, "R1", "other data bits");
    ctl_write(32'h0020_0000);
    chk({31'd0, prev_en}, 1, "R1", "enable with capability");
  endtask

  task automatic t_basic_rules();
    access(0, 0, 0, 0, 1, 0, 4, 4'hF, 4'h0, 0, "R2", "paging off bad xlat");
    access(1, 0, 0, 0, 1, 1, 4, 4'hF, 4'h0, 0, "R2", "paging off write");
    access(0, 0, 0, 1, 0, 0, 4, 4'h0, 4'hF, 1, "R3", "invalid translation");
    access(0, 3, 0, 1, 0, 1, 4, 4'hF, 4'hF, 0, "R4", "plain app access");
    access(0, 2, 0, 1, 0, 1, 4, 4'hF, 4'hF, 1, "R4", "priv2 is supervisor");
    access(0, 0, 0, 1, 0, 1, 4, 4'hF, 4'hF, 1, "R5", "read user page");
    access(0, 0, 0, 1, 0, 1, 4, 4'hD, 4'hF, 0, "R5", "read sup-only page");
  endtask

  task automatic t_override();
    cmd(1, 0);
    chk({31'd0, ovr_flag}, 1, "R11", "set command");
    access(0, 1, 0, 1, 0, 1, 4, 4'hF, 4'hF, 0, "R6", "override lifts rule");
    access(0, 3, 1, 1, 0, 1, 4, 4'hF, 4'hF, 1, "R7", "implicit ignores override");
    access(0, 3, 1, 1, 0, 1, 4, 4'h7, 4'hF, 0, "R7", "implicit sup-only page");
    cmd(1, 1);
    chk({31'd0, ovr_flag}, 0, "R11", "clear wins");
  endtask

  task automatic t_writes();
    access(1, 2, 0, 1, 0, 1, 4, 4'hF, 4'h0, 1, "R8", "write with enable");
    chk({31'd0, res_write}, 1, "R12", "write echo");
    access(1, 2, 0, 1, 0, 1, 4, 4'hE, 4'h0, 0, "R8", "write sup page wp off");
    access(1, 1, 0, 1, 1, 1, 4, 4'hE, 4'hB, 1, "R9", "wp read-only level");
    access(1, 1, 0, 1, 1, 1, 4, 4'hF, 4'hF, 1, "R9", "wp ok but user page");
    access(0, 1, 0, 1, 1, 1, 4, 4'hE, 4'h0, 0, "R9", "wp ignores reads");
    ctl_write(32'h0);
    access(1, 0, 0, 1, 0, 1, 4, 4'hF, 4'h0, 0, "R8", "write enable off");
    access(1, 0, 0, 1, 1, 1, 4, 4'hF, 4'hF, 0, "R9", "wp all writable");
    ctl_write(32'h0020_0000);
  endtask

  task automatic t_levels();
    access(0, 0, 0, 1, 0, 1, 2, 4'hB, 4'hF, 1, "R10", "level2 unused");
    access(0, 0, 0, 1, 0, 1, 3, 4'hB, 4'hF, 0, "R10", "level2 used");
    access(0, 0, 0, 1, 0, 1, 0, 4'h7, 4'hF, 1, "R10", "count 0 clamps to 2");
    access(0, 0, 0, 1, 0, 1, 7, 4'h7, 4'hF, 0, "R10", "count 7 clamps to 4");
    access(1, 0, 0, 1, 1, 1, 2, 4'h3, 4'h3, 1, "R10", "rw unused levels");
  endtask

  task automatic t_cmd_gate();
    cap_vec = '0;
    cmd(1, 0);
    chk({31'd0, ovr_flag}, 0, "R11", "set without capability");
    chk({31'd0, illegal_op}, 1, "R11", "illegal pulse");
    @(negedge clk);
    chk({31'd0, illegal_op}, 0, "R11", "illegal pulse ends");
    cap_vec = 32'h0010_0000;
    cmd(1, 0);
    cap_vec = '0;
    cmd(0, 1);
    chk({31'd0, ovr_flag}, 1, "R11", "clear without capability");
    cap_vec = 32'h0010_0000;
    cmd(0, 1);
    chk({31'd0, ovr_flag}, 0, "R11", "clear command");
    chk({31'd0, illegal_op}, 0, "R11", "no pulse with capability");
  endtask

  task automatic t_backpressure();
    res_ready = 1'b0;
    access(1, 0, 0, 1, 0, 1, 4, 4'hF, 4'hF, 1, "R12", "stalled fault");
    chk({31'd0, req_ready}, 0, "R12", "not ready while held");
    @(negedge clk);
    chk({31'd0, res_valid}, 1, "R12", "held valid");
    chk({31'd0, res_fault}, 1, "R12", "held fault");
    res_ready = 1'b1;
    @(negedge clk);
    chk({31'd0, res_valid}, 0, "R12", "released");
    chk({31'd0, res_fault}, 0, "R12", "fault pulse ended");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_gate();
    t_basic_rules();
    t_override();
    t_writes();
    t_levels();
    t_cmd_gate();
    t_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule